// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Early Warning

This block is a memory-mapped watchdog with two independent 32-bit down-counters. The main counter guards the system. A second counter, loaded by software with a shorter count, fires an early-warning interrupt so that software gets a chance to act before the main counter runs out. Each counter has its own enable and its own clock-source select. A counter steps either on a system-clock tick divided by a programmable power of two or on a fixed-reference tick enable that is synchronous to the bus clock.

Software reaches the block through a simple single-cycle register bus. A write takes effect at the clock edge. A read is combinational on the current address. Software refreshes the watchdog by writing its count register, and it reads the same register to learn the count that remains. When a counter expires, the block sets a sticky status flag and sends a one-cycle interrupt pulse. When the main counter expires, the block can also drive a fixed-length reset pulse. That pulse appears only when a reset-out enable bit is set and a separate reset-out mask bit is clear.

Top module: `wdog_pretimer`

## Requirements
- R1: After reset the control and status registers read 0, both counters read 0xFFFFFFFF, the reset-out enable register (0x40) reads 0, the mask register (0x44) reads 0x400 (masked), and all three outputs are low.
- R2: Register map: control 0x00, status 0x04, early-warning count 0x1C, watchdog count 0x34, reset-out enable 0x40 (bit 8), reset-out mask 0x44 (bit 10). Control keeps only bits 2, 8, 10, 12 and 20:16. All other bits read 0. Unmapped addresses read 0.
- R3: Control bits 20:16 hold a ratio r. Every counter that does not select the reference tick steps once every 2^r system clocks, on the cycle in which a free-running prescaler that starts at 0 from reset has its low r bits all ones.
- R4: Control bit 10 makes the watchdog counter step on refTick, and bit 12 does the same for the early-warning counter, in place of the prescaled tick.
- R5: An enabled watchdog counter (control bit 8) decrements by one per tick. The step from 1 to 0 sets status bit 31 and pulses wdIrq high for exactly one cycle. The counter then holds at 0 until it is reloaded.
- R6: Writing status clears each flag whose bit is written 0 and keeps each flag whose bit is written 1. If an expiry happens in the same cycle as a clearing write, the flag is set.
- R7: Writing a count register loads that counter at the edge, whether or not it is enabled. The load wins over a tick in the same cycle. Reading the register returns the present count.
- R8: While its enable bit is 0, a counter holds its value.
- R9: rstOut is high only while reset-out enable is 1 and the mask bit is 0. Closing either gate drops rstOut in the same cycle.
- R10: On a set watchdog flag with the gate open, rstOut goes high one cycle later for RST_CYCLES cycles. It does not retrigger until the flag has been cleared.
- R11: The early-warning counter (enable control bit 2) behaves as in R5 but sets status bit 8 and pulses preIrq, and it has no effect on rstOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Write strobe, one cycle per write |
| busAddr | input | ADDR_W | Byte address of the register |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data for busAddr, combinational |
| refTick | input | 1 | Fixed-reference tick enable, one cycle wide |
| preIrq | output | 1 | Early-warning expiry pulse |
| wdIrq | output | 1 | Watchdog expiry pulse |
| rstOut | output | 1 | Gated reset pulse |

## Verification
A wrong prescaler phase or a wrong tick select shows in the count read back, on the first tick where it differs from the expected step. The bench reads a count register almost every cycle, so the error appears within 2^r cycles. A flag held wrong, or a reset pulse that fires again, shows on the status read or on rstOut in the cycle after the faulty edge, because the bench model predicts every output and every read cycle by cycle. A gate that is applied late shows in the same cycle the mask is written, since rstOut is expected to drop at once.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W   = 32;
  localparam int RATIO_W = 5;
  localparam int NCH     = 2;
  localparam int CH_PRE  = 0;
  localparam int CH_WD   = 1;

  localparam int OFS_CTRL    = 'h00;
  localparam int OFS_STAT    = 'h04;
  localparam int OFS_PRECNT  = 'h1C;
  localparam int OFS_WDCNT   = 'h34;
  localparam int OFS_RSTEN   = 'h40;
  localparam int OFS_RSTMASK = 'h44;

  localparam int CB_RATIO = 16;
  localparam int RB_EN    = 8;
  localparam int RB_MASK  = 10;

  // per-channel layout, index 0 = early warning, 1 = watchdog
  localparam int CH_RUN_BIT  [NCH] = '{2, 8};
  localparam int CH_REF_BIT  [NCH] = '{12, 10};
  localparam int CH_STAT_BIT [NCH] = '{8, 31};
  localparam int CH_CNT_OFS  [NCH] = '{OFS_PRECNT, OFS_WDCNT};

  typedef struct packed {
    logic [NCH-1:0]     load;
    logic [CNT_W-1:0]   loadVal;
    logic [NCH-1:0]     run;
    logic [NCH-1:0]     useRef;
    logic [RATIO_W-1:0] ratio;
  } dpCtl_t;
endpackage

// File: rtl/wdog_downcnt.sv
module wdog_downcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  input  logic         run,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic         expEvt,
  output logic         irq
);
  logic stepNow;

  assign stepNow = run && tick && (cnt != '0);
  assign expEvt  = !load && stepNow && (cnt == W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '1;
      irq <= 1'b0;
    end else begin
      irq <= expEvt;
      if (load)         cnt <= loadVal;
      else if (stepNow) cnt <= cnt - W'(1);
    end
  end
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  dpCtl_t                    ctl,
  input  logic                      refTick,
  output logic [NCH-1:0][CNT_W-1:0] cntVal,
  output logic [NCH-1:0]            expEvt,
  output logic [NCH-1:0]            irq
);
  localparam int PSC_W = 1 << RATIO_W;

  logic [PSC_W-1:0] psc;
  logic [PSC_W-1:0] pscMask;
  logic             sysTick;

  assign pscMask = (PSC_W'(1) << ctl.ratio) - PSC_W'(1);
  assign sysTick = (psc & pscMask) == pscMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) psc <= '0;
    else       psc <= psc + PSC_W'(1);
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic chTick;
    assign chTick = ctl.useRef[ch] ? refTick : sysTick;

    wdog_downcnt #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rstN   (rstN),
      .load   (ctl.load[ch]),
      .loadVal(ctl.loadVal),
      .run    (ctl.run[ch]),
      .tick   (chTick),
      .cnt    (cntVal[ch]),
      .expEvt (expEvt[ch]),
      .irq    (irq[ch])
    );
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int RST_CYCLES = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      busWr,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [31:0]               busWData,
  output logic [31:0]               busRData,
  input  logic [NCH-1:0][CNT_W-1:0] cntVal,
  input  logic [NCH-1:0]            expEvt,
  output dpCtl_t                    ctl,
  output logic [NCH-1:0]            statFlag,
  output logic                      pulseActive,
  output logic                      gateOk
);
  localparam int RC_W = $clog2(RST_CYCLES + 1);

  logic [NCH-1:0]     runQ;
  logic [NCH-1:0]     refQ;
  logic [RATIO_W-1:0] ratioQ;
  logic               rstEnQ;
  logic               rstMaskQ;
  logic               firedQ;
  logic [RC_W-1:0]    rstCnt;
  logic               ctrlWr, statWr, enWr, maskWr, trig;

  assign ctrlWr = busWr && (busAddr == ADDR_W'(OFS_CTRL));
  assign statWr = busWr && (busAddr == ADDR_W'(OFS_STAT));
  assign enWr   = busWr && (busAddr == ADDR_W'(OFS_RSTEN));
  assign maskWr = busWr && (busAddr == ADDR_W'(OFS_RSTMASK));

  assign ctl.loadVal = busWData;
  assign ctl.run     = runQ;
  assign ctl.useRef  = refQ;
  assign ctl.ratio   = ratioQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ratioQ <= '0;
    else if (ctrlWr) ratioQ <= busWData[CB_RATIO +: RATIO_W];
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    assign ctl.load[ch] = busWr && (busAddr == ADDR_W'(CH_CNT_OFS[ch]));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        runQ[ch] <= 1'b0;
        refQ[ch] <= 1'b0;
      end else if (ctrlWr) begin
        runQ[ch] <= busWData[CH_RUN_BIT[ch]];
        refQ[ch] <= busWData[CH_REF_BIT[ch]];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            statFlag[ch] <= 1'b0;
      else if (expEvt[ch])  statFlag[ch] <= 1'b1;
      else if (statWr)      statFlag[ch] <= statFlag[ch] & busWData[CH_STAT_BIT[ch]];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstEnQ   <= 1'b0;
      rstMaskQ <= 1'b1;
    end else begin
      if (enWr)   rstEnQ   <= busWData[RB_EN];
      if (maskWr) rstMaskQ <= busWData[RB_MASK];
    end
  end

  // reset pulse: one shot per watchdog flag lifetime
  assign gateOk = rstEnQ && !rstMaskQ;
  assign trig   = statFlag[CH_WD] && !firedQ && gateOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firedQ <= 1'b0;
      rstCnt <= '0;
    end else begin
      if (!statFlag[CH_WD]) firedQ <= 1'b0;
      else if (trig)        firedQ <= 1'b1;
      if (trig)                rstCnt <= RC_W'(RST_CYCLES);
      else if (rstCnt != '0)   rstCnt <= rstCnt - RC_W'(1);
    end
  end

  assign pulseActive = (rstCnt != '0);

  always_comb begin
    busRData = '0;
    case (busAddr)
      ADDR_W'(OFS_CTRL): begin
        for (int ch = 0; ch < NCH; ch++) begin
          busRData[CH_RUN_BIT[ch]] = runQ[ch];
          busRData[CH_REF_BIT[ch]] = refQ[ch];
        end
        busRData[CB_RATIO +: RATIO_W] = ratioQ;
      end
      ADDR_W'(OFS_STAT): begin
        for (int ch = 0; ch < NCH; ch++) busRData[CH_STAT_BIT[ch]] = statFlag[ch];
      end
      ADDR_W'(OFS_PRECNT):  busRData = cntVal[CH_PRE];
      ADDR_W'(OFS_WDCNT):   busRData = cntVal[CH_WD];
      ADDR_W'(OFS_RSTEN):   busRData[RB_EN] = rstEnQ;
      ADDR_W'(OFS_RSTMASK): busRData[RB_MASK] = rstMaskQ;
      default:              busRData = '0;
    endcase
  end
endmodule

// File: rtl/wdog_pretimer.sv
module wdog_pretimer
  import wdog_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWData,
  output logic [31:0]       busRData,
  input  logic              refTick,
  output logic              preIrq,
  output logic              wdIrq,
  output logic              rstOut
);
  dpCtl_t                    dpCtl;
  logic [NCH-1:0][CNT_W-1:0] cntVal;
  logic [NCH-1:0]            expEvt;
  logic [NCH-1:0]            irqVec;
  logic [NCH-1:0]            statFlag;
  logic                      pulseActive;
  logic                      gateOk;

  wdog_ctrl #(.ADDR_W(ADDR_W), .RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWr      (busWr),
    .busAddr    (busAddr),
    .busWData   (busWData),
    .busRData   (busRData),
    .cntVal     (cntVal),
    .expEvt     (expEvt),
    .ctl        (dpCtl),
    .statFlag   (statFlag),
    .pulseActive(pulseActive),
    .gateOk     (gateOk)
  );

  wdog_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (dpCtl),
    .refTick(refTick),
    .cntVal (cntVal),
    .expEvt (expEvt),
    .irq    (irqVec)
  );

  assign preIrq = irqVec[CH_PRE];
  assign wdIrq  = irqVec[CH_WD];
  assign rstOut = pulseActive && gateOk;
endmodule

// File: rtl/wdog_pretimer_chk.sv
module wdog_pretimer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wdIrq,
  input logic        preIrq,
  input logic        wdFlag,
  input logic        loadWd,
  input logic        runWd,
  input logic [31:0] wdCnt,
  input logic        pulseActive,
  input logic        gateOk
);
  p_irq_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    wdIrq |=> !wdIrq);

  p_irq_sets_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    wdIrq |-> wdFlag);

  p_zero_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wdCnt == 32'd0 && !loadWd) |=> (wdCnt == 32'd0));

  p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!runWd && !loadWd) |=> $stable(wdCnt));

  p_single_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (runWd && !loadWd) |=> (wdCnt == $past(wdCnt) || wdCnt == $past(wdCnt) - 32'd1));

  p_pre_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    preIrq |=> !preIrq);

  p_pulse_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseActive) |-> $past(wdFlag && gateOk));
endmodule

bind wdog_pretimer wdog_pretimer_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wdIrq      (wdIrq),
  .preIrq     (preIrq),
  .wdFlag     (statFlag[1]),
  .loadWd     (dpCtl.load[1]),
  .runWd      (dpCtl.run[1]),
  .wdCnt      (cntVal[1]),
  .pulseActive(pulseActive),
  .gateOk     (gateOk)
);

// File: tb/tb_wdog_pretimer.sv
module tb_wdog_pretimer;
  localparam int RSTN_CYC = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWData = 32'h0;
  logic [31:0] busRData;
  logic        refTick = 1'b0;
  logic        preIrq, wdIrq, rstOut;

  int checks = 0;
  int errors = 0;
  int tbCyc = 0;
  int refPer = 0;
  bit done = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  wdog_pretimer #(.ADDR_W(8), .RST_CYCLES(RSTN_CYC)) dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWData(busWData), .busRData(busRData), .refTick(refTick),
    .preIrq(preIrq), .wdIrq(wdIrq), .rstOut(rstOut)
  );

  // behavioural reference model, index 0 early warning, 1 watchdog
  logic [31:0] mCtrl, mPsc;
  logic [31:0] mCnt [2];
  bit          mFlag [2];
  bit          mIrq [2];
  bit          mRstEn, mMask, mFired;
  int          mRstCnt;

  function automatic int runBit(int i);  return (i == 0) ? 2 : 8;  endfunction
  function automatic int refBit(int i);  return (i == 0) ? 12 : 10; endfunction
  function automatic int statBit(int i); return (i == 0) ? 8 : 31; endfunction
  function automatic logic [7:0] cntAddr(int i); return (i == 0) ? 8'h1C : 8'h34; endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 0; mPsc = 0; mRstEn = 0; mMask = 1; mFired = 0; mRstCnt = 0;
      for (int i = 0; i < 2; i++) begin mCnt[i] = 32'hFFFF_FFFF; mFlag[i] = 0; mIrq[i] = 0; end
    end else begin
      logic [31:0] msk;
      bit sysT, tk, gate, oldWdFlag, trg;
      bit ev [2];
      msk = (32'd1 << mCtrl[20:16]) - 32'd1;
      sysT = ((mPsc & msk) == msk);
      mPsc = mPsc + 1;
      for (int i = 0; i < 2; i++) begin
        tk = mCtrl[refBit(i)] ? refTick : sysT;
        ev[i] = 0;
        if (busWr && busAddr == cntAddr(i)) mCnt[i] = busWData;
        else if (mCtrl[runBit(i)] && tk && mCnt[i] != 0) begin
          if (mCnt[i] == 1) ev[i] = 1;
          mCnt[i] = mCnt[i] - 1;
        end
      end
      gate = mRstEn && !mMask;
      oldWdFlag = mFlag[1];
      trg = oldWdFlag && !mFired && gate;
      if (!oldWdFlag) mFired = 0; else if (trg) mFired = 1;
      if (trg) mRstCnt = RSTN_CYC; else if (mRstCnt > 0) mRstCnt--;
      for (int i = 0; i < 2; i++) begin
        if (ev[i]) mFlag[i] = 1;
        else if (busWr && busAddr == 8'h04) mFlag[i] = mFlag[i] & busWData[statBit(i)];
        mIrq[i] = ev[i];
      end
      if (busWr && busAddr == 8'h00) mCtrl = busWData & 32'h001F_1504;
      if (busWr && busAddr == 8'h40) mRstEn = busWData[8];
      if (busWr && busAddr == 8'h44) mMask = busWData[10];
    end
  end

  function automatic logic [31:0] mRd(logic [7:0] a);
    logic [31:0] v = 0;
    case (a)
      8'h00: v = mCtrl;
      8'h04: begin v[31] = mFlag[1]; v[8] = mFlag[0]; end
      8'h1C: v = mCnt[0];
      8'h34: v = mCnt[1];
      8'h40: v[8] = mRstEn;
      8'h44: v[10] = mMask;
      default: v = 0;
    endcase
    return v;
  endfunction

  function automatic string rdTag(logic [7:0] a);
    case (a)
      8'h04: return "R6";
      8'h1C: return "R11";
      8'h34: return "R7";
      8'h40, 8'h44: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s/%s %s act=%h exp=%h", phase, tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk(busRData, mRd(busAddr), rdTag(busAddr), "rdata");
    chk({31'b0, wdIrq}, {31'b0, mIrq[1]}, "R5", "wdIrq");
    chk({31'b0, preIrq}, {31'b0, mIrq[0]}, "R11", "preIrq");
    chk({31'b0, rstOut}, {31'b0, (mRstCnt != 0) && mRstEn && !mMask}, "R10", "rstOut");
  endtask

  task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = w; busAddr = a; busWData = d;
    refTick = (refPer != 0) && (tbCyc % refPer == 0);
    tbCyc++;
    #1;
    compareAll();
  endtask

  task automatic idle(input int n, input logic [7:0] a);
    repeat (n) step(1'b0, a, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: reset values, hand-computed as well as via the model
    phase = "R1";
    step(0, 8'h34, 0); chk(busRData, 32'hFFFF_FFFF, "R1", "wd count at reset");
    step(0, 8'h44, 0); chk(busRData, 32'h0000_0400, "R1", "mask at reset");
    step(0, 8'h00, 0); chk(busRData, 32'h0, "R1", "ctrl at reset");
    step(0, 8'h04, 0); step(0, 8'h1C, 0); step(0, 8'h40, 0);

    // R5 / R11: both counters, ratio 0
    phase = "R5";
    step(1, 8'h1C, 32'd12);
    step(1, 8'h34, 32'd30);
    step(1, 8'h00, 32'h0000_0104);
    idle(40, 8'h34);
    idle(2, 8'h1C);
    step(0, 8'h04, 0); chk(busRData, 32'h8000_0100, "R5", "both flags set");

    // R6: write-1 keeps, write-0 clears per bit
    phase = "R6";
    step(1, 8'h04, 32'hFFFF_FFFF); step(0, 8'h04, 0);
    step(1, 8'h04, 32'h8000_0000); step(0, 8'h04, 0);
    chk(busRData, 32'h8000_0000, "R6", "only pre flag cleared");
    step(1, 8'h04, 32'h0); step(0, 8'h04, 0);

    // R10 / R9: reset pulse, no retrigger, mask drops it
    phase = "R10";
    step(1, 8'h40, 32'h0000_0100);
    step(1, 8'h44, 32'h0);
    step(1, 8'h34, 32'd4);
    idle(30, 8'h04);
    step(1, 8'h04, 32'h0);
    idle(3, 8'h04);
    step(1, 8'h34, 32'd3);
    idle(8, 8'h34);
    phase = "R9";
    step(1, 8'h44, 32'h0000_0400);
    idle(4, 8'h44);
    step(1, 8'h44, 32'h0);
    idle(20, 8'h40);
    step(1, 8'h04, 32'h0);

    // R3: prescaled tick, ratio 3
    phase = "R3";
    step(1, 8'h00, 32'h0003_0100);
    step(1, 8'h34, 32'd9);
    idle(90, 8'h34);

    // R8: stopped counter holds, load still works (R7)
    phase = "R8";
    step(1, 8'h34, 32'd50);
    step(1, 8'h00, 32'h0003_0000);
    idle(20, 8'h34);
    step(1, 8'h34, 32'd7);
    idle(5, 8'h34);
    chk(busRData, 32'd7, "R8", "stopped count holds load");

    // R4: reference tick drives both counters
    phase = "R4";
    refPer = 5;
    step(1, 8'h1C, 32'd6);
    step(1, 8'h34, 32'd10);
    step(1, 8'h00, 32'h0002_1504);
    idle(35, 8'h1C);
    idle(35, 8'h34);
    refPer = 0;
    step(1, 8'h34, 32'd3);
    idle(12, 8'h34);
    chk(busRData, 32'd3, "R4", "no ref tick, no step");

    // R2: control field mask
    phase = "R2";
    step(1, 8'h00, 32'hFFFF_FFFF); step(0, 8'h00, 0);
    chk(busRData, 32'h001F_1504, "R2", "ctrl readback mask");
    step(1, 8'h00, 32'h0); step(0, 8'h08, 0);
    chk(busRData, 32'h0, "R2", "unmapped read");
    idle(4, 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule